// File: doc/BRIEF.md
# Status Writeback Committer with Flag Arbitration

This block sits at the end of an instruction slot. It commits a small batch of queued 32-bit register writes in one clock. Each queued write names a target register, a bit mask and a data word. Only the masked bits of the target change. The targets are the status word, its two saved copies (backup and debug), and the active stack pointer.

When two execution units in the same slot both write condition flags of the status word, the later write in the queue wins. A later write of the overflow flag also cancels the earlier write's accumulated-overflow bit. After the writes, the block applies trap entry to the status word. Last, it swaps the banked stack pointers when the stack-mode bit changes. A wide accumulator write is committed beside the batch without a mask.

Top module: `status_writeback`

## Requirements
- R1: A valid write in slot k sets its target to (old AND NOT mask) OR (data AND mask). The select encoding is 0 = status, 1 = backup status, 2 = debug status, 3 = active stack pointer. The result is visible on the matching output in the cycle after the write.
- R2: Writes in one cycle are applied in slot order, lowest slot first. Where two writes to the same register overlap, the higher slot's bits win. Bits covered only by the lower slot keep that slot's value.
- R3: Status bits use MSB-first numbering: flag number n is vector bit 31-n. The arbitrated flags are F0 (bit 14), F1 (12), F2 (10), F3 (8), S (6), V (5), VA (4) and C (3). If an earlier status write and a later status write share any flag bit, the earlier write loses those shared flag bits. If the later mask also holds V, the earlier write loses VA as well, even when the later mask lacks VA.
- R4: The earlier write keeps its VA bit in two cases: the two status writes share no flag bit, or the later write targets a register other than status.
- R5: When sys_move is high, no flag arbitration takes place, and every write applies its full mask.
- R6: Trap code 1 copies the status word, after that cycle's writes, into the backup status. It then clears every status bit except DB (bit 28) and SM (bit 31).
- R7: Trap code 2 copies the status word, after that cycle's writes, into the debug status. It then leaves only DS (bit 27) set. Trap codes 0 and 3 leave both saved copies and the status word untouched.
- R8: sp_bank always equals status bit SM. When SM changes, the active stack pointer is saved into its bank and the other bank's saved value becomes active. A stack-pointer write in the same cycle is the value that gets saved.
- R9: When acc_vld is high, acc_q takes acc_data whole in the next cycle.
- R10: Reset clears every output, and both stack-pointer banks, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_vld | input | NSLOT | Per-slot write valid |
| wr_sel | input | NSLOT x 2 | Per-slot target register select |
| wr_mask | input | NSLOT x 32 | Per-slot bit mask |
| wr_data | input | NSLOT x 32 | Per-slot write data |
| sys_move | input | 1 | First slot was a move to a system register; disables arbitration |
| trap_code | input | 2 | 0 none, 1 ordinary trap, 2 debug trap, 3 none |
| acc_vld | input | 1 | Accumulator write valid |
| acc_data | input | ACC_W | Accumulator write data |
| status_q | output | 32 | Status word |
| bkup_q | output | 32 | Backup status copy |
| dbg_q | output | 32 | Debug status copy |
| sp_q | output | 32 | Active stack pointer |
| sp_bank | output | 1 | Selected stack-pointer bank |
| acc_q | output | ACC_W | Accumulator |

## Verification
The bench uses the default values: two write slots and a 64-bit accumulator. With two slots, every pairing of an earlier and a later write is reachable. That covers flag overlap with and without V, status against a non-status target, and same-register ordering on the saved copies. The 64-bit width lets the accumulator check show that both halves are carried through whole.

// File: rtl/stwb_pkg.sv
package stwb_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_STATUS = 2'd0;
  localparam logic [SEL_W-1:0] SEL_BKUP   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DBG    = 2'd2;
  localparam logic [SEL_W-1:0] SEL_SP     = 2'd3;

  localparam logic [1:0] TRAP_ORD = 2'd1;
  localparam logic [1:0] TRAP_DBG = 2'd2;

  // MSB-first numbering: flag number n sits at vector bit DATA_W-1-n
  localparam int POS_SM = DATA_W - 1 - 0;
  localparam int POS_DB = DATA_W - 1 - 3;
  localparam int POS_DS = DATA_W - 1 - 4;
  localparam int POS_F0 = DATA_W - 1 - 17;
  localparam int POS_F1 = DATA_W - 1 - 19;
  localparam int POS_F2 = DATA_W - 1 - 21;
  localparam int POS_F3 = DATA_W - 1 - 23;
  localparam int POS_S  = DATA_W - 1 - 25;
  localparam int POS_V  = DATA_W - 1 - 26;
  localparam int POS_VA = DATA_W - 1 - 27;
  localparam int POS_C  = DATA_W - 1 - 28;

  function automatic logic [DATA_W-1:0] bit_at(input int pos);
    logic [DATA_W-1:0] r;
    r = '0;
    r[pos] = 1'b1;
    return r;
  endfunction

  localparam logic [DATA_W-1:0] FLAG_MASK =
      bit_at(POS_F0) | bit_at(POS_F1) | bit_at(POS_F2) | bit_at(POS_F3) |
      bit_at(POS_S)  | bit_at(POS_V)  | bit_at(POS_VA) | bit_at(POS_C);

  function automatic logic [DATA_W-1:0] masked_merge(
      input logic [DATA_W-1:0] old_v,
      input logic [DATA_W-1:0] m,
      input logic [DATA_W-1:0] d);
    return (old_v & ~m) | (d & m);
  endfunction
endpackage

// File: rtl/stwb_flag_arb.sv
module stwb_flag_arb
  import stwb_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic [NSLOT-1:0]             vld,
  input  logic [NSLOT-1:0][SEL_W-1:0]  sel,
  input  logic [NSLOT-1:0][DATA_W-1:0] mask,
  input  logic                         sys_move,
  output logic [NSLOT-1:0][DATA_W-1:0] eff_mask
);
  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      eff_mask[i] = mask[i];
      if (!sys_move && vld[i] && (sel[i] == SEL_STATUS)) begin
        for (int j = i + 1; j < NSLOT; j++) begin
          if (vld[j] && (sel[j] == SEL_STATUS) &&
              (|(mask[j] & mask[i] & FLAG_MASK))) begin
            eff_mask[i] = eff_mask[i] & ~(mask[j] & FLAG_MASK);
            if (mask[j][POS_V]) eff_mask[i][POS_VA] = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stwb_merge.sv
module stwb_merge
  import stwb_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input  logic [DATA_W-1:0]            st_i,
  input  logic [DATA_W-1:0]            bk_i,
  input  logic [DATA_W-1:0]            dbg_i,
  input  logic [DATA_W-1:0]            sp_i,
  input  logic [NSLOT-1:0]             vld,
  input  logic [NSLOT-1:0][SEL_W-1:0]  sel,
  input  logic [NSLOT-1:0][DATA_W-1:0] eff_mask,
  input  logic [NSLOT-1:0][DATA_W-1:0] data,
  output logic [DATA_W-1:0]            st_o,
  output logic [DATA_W-1:0]            bk_o,
  output logic [DATA_W-1:0]            dbg_o,
  output logic [DATA_W-1:0]            sp_o
);
  always_comb begin
    st_o  = st_i;
    bk_o  = bk_i;
    dbg_o = dbg_i;
    sp_o  = sp_i;
    for (int i = 0; i < NSLOT; i++) begin
      if (vld[i]) begin
        case (sel[i])
          SEL_STATUS: st_o  = masked_merge(st_o,  eff_mask[i], data[i]);
          SEL_BKUP:   bk_o  = masked_merge(bk_o,  eff_mask[i], data[i]);
          SEL_DBG:    dbg_o = masked_merge(dbg_o, eff_mask[i], data[i]);
          default:    sp_o  = masked_merge(sp_o,  eff_mask[i], data[i]);
        endcase
      end
    end
  end
endmodule

// File: rtl/stwb_trap_swap.sv
module stwb_trap_swap
  import stwb_pkg::*;
(
  input  logic [DATA_W-1:0] st_w,
  input  logic [DATA_W-1:0] bk_w,
  input  logic [DATA_W-1:0] dbg_w,
  input  logic [DATA_W-1:0] sp_w,
  input  logic [DATA_W-1:0] spare_i,
  input  logic              bank_i,
  input  logic [1:0]        trap_code,
  output logic [DATA_W-1:0] st_n,
  output logic [DATA_W-1:0] bk_n,
  output logic [DATA_W-1:0] dbg_n,
  output logic [DATA_W-1:0] sp_n,
  output logic [DATA_W-1:0] spare_n,
  output logic              bank_n
);
  always_comb begin
    st_n  = st_w;
    bk_n  = bk_w;
    dbg_n = dbg_w;
    case (trap_code)
      TRAP_ORD: begin
        bk_n = st_w;
        st_n = st_w & (bit_at(POS_DB) | bit_at(POS_SM));
      end
      TRAP_DBG: begin
        dbg_n = st_w;
        st_n  = bit_at(POS_DS);
      end
      default: ;
    endcase
    bank_n  = st_n[POS_SM];
    sp_n    = sp_w;
    spare_n = spare_i;
    if (bank_n != bank_i) begin
      spare_n = sp_w;
      sp_n    = spare_i;
    end
  end
endmodule

// File: rtl/status_writeback.sv
module status_writeback
  import stwb_pkg::*;
#(
  parameter int NSLOT = 2,
  parameter int ACC_W = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSLOT-1:0]             wr_vld,
  input  logic [NSLOT-1:0][SEL_W-1:0]  wr_sel,
  input  logic [NSLOT-1:0][DATA_W-1:0] wr_mask,
  input  logic [NSLOT-1:0][DATA_W-1:0] wr_data,
  input  logic                         sys_move,
  input  logic [1:0]                   trap_code,
  input  logic                         acc_vld,
  input  logic [ACC_W-1:0]             acc_data,
  output logic [DATA_W-1:0]            status_q,
  output logic [DATA_W-1:0]            bkup_q,
  output logic [DATA_W-1:0]            dbg_q,
  output logic [DATA_W-1:0]            sp_q,
  output logic                         sp_bank,
  output logic [ACC_W-1:0]             acc_q
);
  logic [NSLOT-1:0][DATA_W-1:0] eff_mask;
  logic [DATA_W-1:0] st_w, bk_w, dbg_w, sp_w;
  logic [DATA_W-1:0] st_n, bk_n, dbg_n, sp_n, spare_n;
  logic [DATA_W-1:0] spare_q;
  logic              bank_n;
  logic              upd_en;

  stwb_flag_arb #(.NSLOT(NSLOT)) u_arb (
    .vld(wr_vld), .sel(wr_sel), .mask(wr_mask),
    .sys_move(sys_move), .eff_mask(eff_mask)
  );

  stwb_merge #(.NSLOT(NSLOT)) u_merge (
    .st_i(status_q), .bk_i(bkup_q), .dbg_i(dbg_q), .sp_i(sp_q),
    .vld(wr_vld), .sel(wr_sel), .eff_mask(eff_mask), .data(wr_data),
    .st_o(st_w), .bk_o(bk_w), .dbg_o(dbg_w), .sp_o(sp_w)
  );

  stwb_trap_swap u_trap (
    .st_w(st_w), .bk_w(bk_w), .dbg_w(dbg_w), .sp_w(sp_w),
    .spare_i(spare_q), .bank_i(sp_bank), .trap_code(trap_code),
    .st_n(st_n), .bk_n(bk_n), .dbg_n(dbg_n), .sp_n(sp_n),
    .spare_n(spare_n), .bank_n(bank_n)
  );

  assign upd_en = (|wr_vld) || (trap_code == TRAP_ORD) || (trap_code == TRAP_DBG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      bkup_q   <= '0;
      dbg_q    <= '0;
      sp_q     <= '0;
      spare_q  <= '0;
      sp_bank  <= 1'b0;
    end else if (upd_en) begin
      status_q <= st_n;
      bkup_q   <= bk_n;
      dbg_q    <= dbg_n;
      sp_q     <= sp_n;
      spare_q  <= spare_n;
      sp_bank  <= bank_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (acc_vld) acc_q <= acc_data;
  end

  // Assertions
  generate
    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_ai
      for (genvar gj = gi + 1; gj < NSLOT; gj++) begin : g_aj
        p_flag_arb_r3: assert property (@(posedge clk) disable iff (!rst_n)
          (!sys_move && wr_vld[gi] && wr_vld[gj] &&
           wr_sel[gi] == SEL_STATUS && wr_sel[gj] == SEL_STATUS)
          |-> ((eff_mask[gi] & wr_mask[gj] & FLAG_MASK) == '0));
        p_va_cancel_r3: assert property (@(posedge clk) disable iff (!rst_n)
          (!sys_move && wr_vld[gi] && wr_vld[gj] &&
           wr_sel[gi] == SEL_STATUS && wr_sel[gj] == SEL_STATUS &&
           wr_mask[gj][POS_V] && (|(wr_mask[gi] & wr_mask[gj] & FLAG_MASK)))
          |-> !eff_mask[gi][POS_VA]);
      end
    end
  endgenerate

  p_no_arb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_move |-> (eff_mask == wr_mask));

  p_trap_ord_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_code == TRAP_ORD) |=>
      ((status_q & ~(bit_at(POS_DB) | bit_at(POS_SM))) == '0));

  p_trap_dbg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_code == TRAP_DBG) |=> (status_q == bit_at(POS_DS)));

  p_bank_sm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_bank == status_q[POS_SM]);

  p_swap_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_bank != $past(sp_bank)) |-> (sp_q == $past(spare_q)));

  p_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |=> (acc_q == $past(acc_data)));
endmodule

// File: tb/status_writeback_bench.sv
module status_writeback_bench;
  import stwb_pkg::*;
  localparam int NSLOT = 2;
  localparam int ACC_W = 64;

  logic clk, rst_n;
  logic [NSLOT-1:0]             wr_vld;
  logic [NSLOT-1:0][SEL_W-1:0]  wr_sel;
  logic [NSLOT-1:0][DATA_W-1:0] wr_mask;
  logic [NSLOT-1:0][DATA_W-1:0] wr_data;
  logic sys_move;
  logic [1:0] trap_code;
  logic acc_vld;
  logic [ACC_W-1:0] acc_data;
  logic [DATA_W-1:0] status_q, bkup_q, dbg_q, sp_q;
  logic sp_bank;
  logic [ACC_W-1:0] acc_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  status_writeback #(.NSLOT(NSLOT), .ACC_W(ACC_W)) u_status_writeback (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_sel(wr_sel),
    .wr_mask(wr_mask), .wr_data(wr_data), .sys_move(sys_move),
    .trap_code(trap_code), .acc_vld(acc_vld), .acc_data(acc_data),
    .status_q(status_q), .bkup_q(bkup_q), .dbg_q(dbg_q), .sp_q(sp_q),
    .sp_bank(sp_bank), .acc_q(acc_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic idle();
    wr_vld = '0; wr_sel = '0; wr_mask = '0; wr_data = '0;
    sys_move = 1'b0; trap_code = 2'd0; acc_vld = 1'b0; acc_data = '0;
  endtask

  task automatic chk(input string tag, input logic [ACC_W-1:0] act,
                     input logic [ACC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle, returns at the next falling edge.
  task automatic step(input logic [1:0] v,
                      input logic [1:0] s0, input logic [31:0] m0, input logic [31:0] d0,
                      input logic [1:0] s1, input logic [31:0] m1, input logic [31:0] d1,
                      input logic sm, input logic [1:0] tc);
    wr_vld = v;
    wr_sel[0] = s0; wr_mask[0] = m0; wr_data[0] = d0;
    wr_sel[1] = s1; wr_mask[1] = m1; wr_data[1] = d1;
    sys_move = sm; trap_code = tc;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 status", status_q, 0);
    chk("R10 backup", bkup_q, 0);
    chk("R10 debug", dbg_q, 0);
    chk("R10 sp", sp_q, 0);
    chk("R10 bank", sp_bank, 0);
    chk("R10 acc", acc_q, 0);
  endtask

  task automatic t_masked_r1();
    do_reset();
    step(2'b01, SEL_BKUP, 32'hFFFF_FFFF, 32'h1234_5678, 0, 0, 0, 0, 0);
    chk("R1 full write", bkup_q, 32'h1234_5678);
    step(2'b01, SEL_BKUP, 32'h0000_FFFF, 32'hABCD_EF01, 0, 0, 0, 0, 0);
    chk("R1 masked write", bkup_q, 32'h1234_EF01);
    step(2'b10, 0, 0, 0, SEL_SP, 32'h0000_0FF0, 32'hFFFF_FFFF, 0, 0);
    chk("R1 slot1 sp", sp_q, 32'h0000_0FF0);
  endtask

  task automatic t_order_r2();
    do_reset();
    step(2'b11, SEL_DBG, 32'hFFFF_0000, 32'hAAAA_AAAA,
                SEL_DBG, 32'h00FF_FF00, 32'h5555_5555, 0, 0);
    chk("R2 slot order", dbg_q, 32'hAA55_5500);
  endtask

  task automatic t_arb_r3();
    do_reset();
    // earlier {V,VA,C}=1, later {V}=0: VA cancelled, C kept
    step(2'b11, SEL_STATUS, 32'h0000_0038, 32'hFFFF_FFFF,
                SEL_STATUS, 32'h0000_0020, 32'h0, 0, 0);
    chk("R3 VA cancelled by later V", status_q, 32'h0000_0008);
  endtask

  task automatic t_noarb_r4();
    do_reset();
    step(2'b11, SEL_STATUS, 32'h0000_0010, 32'hFFFF_FFFF,
                SEL_STATUS, 32'h0000_0020, 32'hFFFF_FFFF, 0, 0);
    chk("R4 no overlap keeps VA", status_q, 32'h0000_0030);
    do_reset();
    step(2'b11, SEL_STATUS, 32'h0000_0030, 32'hFFFF_FFFF,
                SEL_BKUP,   32'h0000_0020, 32'hFFFF_FFFF, 0, 0);
    chk("R4 other target status", status_q, 32'h0000_0030);
    chk("R4 other target backup", bkup_q, 32'h0000_0020);
  endtask

  task automatic t_sysmove_r5();
    do_reset();
    step(2'b11, SEL_STATUS, 32'h0000_0038, 32'hFFFF_FFFF,
                SEL_STATUS, 32'h0000_0020, 32'h0, 1, 0);
    chk("R5 sys_move keeps VA", status_q, 32'h0000_0018);
  endtask

  task automatic t_trap_r6_r7();
    do_reset();
    step(2'b01, SEL_STATUS, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    step(2'b00, 0, 0, 0, 0, 0, 0, 0, 2'd1);
    chk("R6 backup copy", bkup_q, 32'hFFFF_FFFF);
    chk("R6 status kept bits", status_q, 32'h9000_0000);
    step(2'b00, 0, 0, 0, 0, 0, 0, 0, 2'd3);
    chk("R7 code3 status", status_q, 32'h9000_0000);
    chk("R7 code3 debug", dbg_q, 32'h0);
    step(2'b01, SEL_STATUS, 32'h0000_00FF, 32'h0000_0042, 0, 0, 0, 0, 2'd2);
    chk("R7 debug copy after writes", dbg_q, 32'h9000_0042);
    chk("R7 status DS only", status_q, 32'h0800_0000);
    chk("R7 backup untouched", bkup_q, 32'hFFFF_FFFF);
  endtask

  task automatic t_stack_r8();
    do_reset();
    step(2'b01, SEL_SP, 32'hFFFF_FFFF, 32'h111, 0, 0, 0, 0, 0);
    chk("R8 sp write", sp_q, 32'h111);
    step(2'b11, SEL_STATUS, 32'h8000_0000, 32'h8000_0000,
                SEL_SP, 32'hFFFF_FFFF, 32'h222, 0, 0);
    chk("R8 bank1 selected", sp_bank, 1);
    chk("R8 bank1 sp", sp_q, 32'h0);
    step(2'b01, SEL_SP, 32'hFFFF_FFFF, 32'h333, 0, 0, 0, 0, 0);
    step(2'b01, SEL_STATUS, 32'h8000_0000, 32'h0, 0, 0, 0, 0, 0);
    chk("R8 back to bank0", sp_bank, 0);
    chk("R8 bank0 restored", sp_q, 32'h222);
    step(2'b01, SEL_STATUS, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 0);
    chk("R8 bank1 restored", sp_q, 32'h333);
  endtask

  task automatic t_acc_r9();
    do_reset();
    acc_vld = 1'b1; acc_data = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk);
    idle();
    chk("R9 acc write", acc_q, 64'hDEAD_BEEF_0123_4567);
    @(negedge clk);
    chk("R9 acc hold", acc_q, 64'hDEAD_BEEF_0123_4567);
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    @(negedge clk);
    t_reset();
    t_masked_r1();
    t_order_r2();
    t_arb_r3();
    t_noarb_r4();
    t_sysmove_r5();
    t_trap_r6_r7();
    t_stack_r8();
    t_acc_r9();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule